// File: doc/BRIEF.md
# Truth-Table Bit-Slice ALU with Flags

This block is a combinational arithmetic and logic unit of configurable width. It is built from identical bit positions and takes three 4-bit truth-table words in place of an opcode. In each bit, the propagate table and the kill table are indexed by the two operand bits. A ripple chain then moves a carry from the low bit to the high bit. The result table is indexed by the bit's propagate value and its incoming carry. Changing the three words changes the operation. The same hardware therefore produces sums, differences and bitwise logic.

The words arrive already decoded from whatever sequences the datapath. Operand, carry and table inputs are plain levels. The result, carry-out, negative flag and zero flag follow the inputs combinationally, with no clock and no handshake inside the block. A surrounding datapath registers them where it needs to.

Top module: `tt_alu`

## Requirements
- R1: Each bit's propagate value equals `prop_tt[{a,b}]`, where a is the bit of `op_a` and b is the bit of `op_b` (index 0 is a=0,b=0 and index 3 is a=1,b=1). With `res_tt = 4'b1100` the result bit equals that propagate value.
- R2: The carry out of a bit is 0 when its kill value (`kill_tt[{a,b}]`) is 1. It equals the incoming carry when propagate is 1 and kill is 0. It is 1 when both are 0. Kill takes priority over propagate.
- R3: Each result bit equals `res_tt[{p,c}]`, where p is that bit's propagate value and c is the carry entering that bit.
- R4: `carry_in` is the carry entering bit 0. The carry leaving the top bit drives `carry_out`. With `prop_tt = 4'b1111`, `kill_tt = 4'b0000` and `res_tt = 4'b1010`, every result bit and `carry_out` equal `carry_in`.
- R5: With `prop_tt = 4'b0110` (XOR), `kill_tt = 4'b0001` (NOR) and `res_tt = 4'b0110` (XOR), `{carry_out, result}` equals `op_a + op_b + carry_in`.
- R6: With `prop_tt = 4'b1001`, `kill_tt = 4'b0010`, `res_tt = 4'b0110` and `carry_in = 1`, `result` equals `op_a - op_b` modulo 2^WIDTH, and `carry_out` is 1 exactly when `op_a >= op_b` (unsigned).
- R7: With `res_tt = 4'b1100`, setting `prop_tt` to 4'b1000, 4'b1110 or 4'b0110 makes `result` the bitwise AND, OR or XOR of the operands respectively.
- R8: `neg_flag` equals the most significant bit of `result`.
- R9: `zero_flag` is 1 exactly when every bit of `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry entering bit 0 |
| prop_tt | input | 4 | Propagate truth table, indexed by {a,b} |
| kill_tt | input | 4 | Kill truth table, indexed by {a,b} |
| res_tt | input | 4 | Result truth table, indexed by {propagate, carry} |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry leaving the top bit |
| neg_flag | output | 1 | Copy of the result's top bit |
| zero_flag | output | 1 | High when the result is all zeros |

## Verification
The block holds no state, so a wrong internal value shows at the ports as soon as the inputs settle, in the same cycle they are applied. A bad table lookup in one bit corrupts only that result bit, and only for the operand pairs that select the faulty entry. The logic settings separate those cases. A fault in the carry chain shows in the bits above the faulty position and in `carry_out`. Full-length carry ripples (all ones plus one, and carry-in passed straight through) catch it at the top bit. Flag faults appear directly against the result word that is visible in the same cycle.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;
  localparam int TT_BITS = 4;

  typedef logic [TT_BITS-1:0] tt_word_t;

  // Select one entry of a 4-entry truth table by a two-bit index
  function automatic logic tt_lookup(input tt_word_t tt, input logic sel_hi,
                                     input logic sel_lo);
    return tt[{sel_hi, sel_lo}];
  endfunction
endpackage

// File: rtl/tt_pk_stage.sv
module tt_pk_stage
  import tt_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  tt_word_t         prop_tt,
  input  tt_word_t         kill_tt,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] kill
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = tt_lookup(prop_tt, op_a[i], op_b[i]);
    assign kill[i] = tt_lookup(kill_tt, op_a[i], op_b[i]);
  end
endmodule

// File: rtl/tt_carry_chain.sv
module tt_carry_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] kill,
  input  logic             carry_in,
  output logic [WIDTH-1:0] carry_vec,
  output logic             carry_out
);
  always_comb begin
    logic c;
    c = carry_in;
    for (int i = 0; i < WIDTH; i++) begin
      carry_vec[i] = c;
      if (kill[i])      c = 1'b0;
      else if (!prop[i]) c = 1'b1;
    end
    carry_out = c;
  end
endmodule

// File: rtl/tt_result_gen.sv
module tt_result_gen
  import tt_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] carry_vec,
  input  tt_word_t         res_tt,
  output logic [WIDTH-1:0] result
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign result[i] = tt_lookup(res_tt, prop[i], carry_vec[i]);
  end
endmodule

// File: rtl/tt_flag_gen.sv
module tt_flag_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] result,
  output logic             neg_flag,
  output logic             zero_flag
);
  localparam int MSB = WIDTH - 1;

  assign neg_flag  = result[MSB];
  assign zero_flag = ~|result;
endmodule

// File: rtl/tt_alu.sv
module tt_alu
  import tt_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic [3:0]       prop_tt,
  input  logic [3:0]       kill_tt,
  input  logic [3:0]       res_tt,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             neg_flag,
  output logic             zero_flag
);
  logic [WIDTH-1:0] prop_w;
  logic [WIDTH-1:0] kill_w;
  logic [WIDTH-1:0] carry_w;

  tt_pk_stage #(.WIDTH(WIDTH)) u_pk (
    .op_a    (op_a),
    .op_b    (op_b),
    .prop_tt (prop_tt),
    .kill_tt (kill_tt),
    .prop    (prop_w),
    .kill    (kill_w)
  );

  tt_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .prop      (prop_w),
    .kill      (kill_w),
    .carry_in  (carry_in),
    .carry_vec (carry_w),
    .carry_out (carry_out)
  );

  tt_result_gen #(.WIDTH(WIDTH)) u_res (
    .prop      (prop_w),
    .carry_vec (carry_w),
    .res_tt    (res_tt),
    .result    (result)
  );

  tt_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .result    (result),
    .neg_flag  (neg_flag),
    .zero_flag (zero_flag)
  );
endmodule

// File: rtl/tt_alu_chk.sv
module tt_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [3:0]       prop_tt,
  input logic [3:0]       kill_tt,
  input logic [3:0]       res_tt,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             neg_flag,
  input logic             zero_flag
);
  always_comb begin
    logic [WIDTH:0] ref_sum;
    ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    // R8
    n_flag_chk: assert (neg_flag == result[WIDTH-1]);
    // R9
    z_flag_chk: assert (zero_flag == (result == '0));
    // R5
    if (prop_tt == 4'b0110 && kill_tt == 4'b0001 && res_tt == 4'b0110)
      add_sum_chk: assert ({carry_out, result} == ref_sum);
    // R2
    if (kill_tt == 4'b1111)
      kill_all_chk: assert (carry_out == 1'b0);
    // R2
    if (prop_tt == 4'b0000 && kill_tt == 4'b0000)
      gen_all_chk: assert (carry_out == 1'b1);
    // R7
    if (prop_tt == 4'b1000 && res_tt == 4'b1100)
      and_mode_chk: assert (result == (op_a & op_b));
  end
endmodule

bind tt_alu tt_alu_chk #(.WIDTH(WIDTH)) u_tt_alu_chk (.*);

// File: tb/tb_tt_alu.sv
`timescale 1ns/1ps
module tb_tt_alu;
  localparam int WIDTH = 8;
  localparam logic [WIDTH-1:0] MASK = {WIDTH{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [WIDTH-1:0] op_a = '0, op_b = '0;
  logic             carry_in = 1'b0;
  logic [3:0]       prop_tt = '0, kill_tt = '0, res_tt = '0;
  logic [WIDTH-1:0] result;
  logic             carry_out, neg_flag, zero_flag;

  int checks = 0;
  int fails  = 0;

  tt_alu #(.WIDTH(WIDTH)) dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .prop_tt(prop_tt), .kill_tt(kill_tt), .res_tt(res_tt),
    .result(result), .carry_out(carry_out),
    .neg_flag(neg_flag), .zero_flag(zero_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input logic ci,
                       input logic [3:0] p, input logic [3:0] k, input logic [3:0] r);
    @(posedge clk);
    op_a = a; op_b = b; carry_in = ci; prop_tt = p; kill_tt = k; res_tt = r;
    @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    check({req, " neg"}, 32'(neg_flag), 32'(result[WIDTH-1]));
    check({req, " zero"}, 32'(zero_flag), 32'(result == '0));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    // all-zero tables: every bit generates, result table gives 0
    check("R2 idle carry", 32'(carry_out), 32'd1);
    check("R3 idle result", 32'(result), 32'd0);
    check("R9 idle zero", 32'(zero_flag), 32'd1);
    check("R8 idle neg", 32'(neg_flag), 32'd0);
  endtask

  task automatic t_add;
    logic [WIDTH:0] sum;
    for (int i = 0; i < 24; i++) begin
      logic [WIDTH-1:0] a, b;
      logic ci;
      a = WIDTH'((i * 37 + 11) & MASK);
      b = WIDTH'((i * 91 + 5) & MASK);
      ci = 1'(i & 1);
      if (i == 0) begin a = MASK; b = 1; ci = 0; end
      if (i == 1) begin a = MASK; b = 0; ci = 1; end
      if (i == 2) begin a = 8'h80; b = 8'h80; ci = 0; end
      if (i == 3) begin a = 8'h7F; b = 8'h01; ci = 0; end
      apply(a, b, ci, 4'b0110, 4'b0001, 4'b0110);
      sum = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(ci);
      check("R5 add result", 32'(result), 32'(sum[WIDTH-1:0]));
      check("R5 add carry", 32'(carry_out), 32'(sum[WIDTH]));
      check_flags("R8 R9 add");
    end
  endtask

  task automatic t_sub;
    for (int i = 0; i < 16; i++) begin
      logic [WIDTH-1:0] a, b, d;
      a = WIDTH'((i * 53 + 3) & MASK);
      b = WIDTH'((i * 29 + 70) & MASK);
      if (i == 0) b = a;
      if (i == 1) begin a = 0; b = 1; end
      apply(a, b, 1'b1, 4'b1001, 4'b0010, 4'b0110);
      d = a - b;
      check("R6 sub result", 32'(result), 32'(d));
      check("R6 sub borrow", 32'(carry_out), 32'(a >= b));
      check_flags("R8 R9 sub");
    end
  endtask

  task automatic t_logic;
    for (int i = 0; i < 8; i++) begin
      logic [WIDTH-1:0] a, b;
      a = WIDTH'((i * 71 + 19) & MASK);
      b = WIDTH'((i * 45 + 200) & MASK);
      apply(a, b, 1'(i & 1), 4'b1000, 4'b0000, 4'b1100);
      check("R7 and", 32'(result), 32'(a & b));
      apply(a, b, 1'b0, 4'b1110, 4'b1111, 4'b1100);
      check("R7 or", 32'(result), 32'(a | b));
      apply(a, b, 1'b1, 4'b0110, 4'b1111, 4'b1100);
      check("R7 xor", 32'(result), 32'(a ^ b));
      // R1: arbitrary propagate table (XNOR) seen through result
      apply(a, b, 1'b0, 4'b1001, 4'b1111, 4'b1100);
      check("R1 prop lookup", 32'(result), 32'(~(a ^ b) & MASK));
    end
  endtask

  task automatic t_carry_rules;
    apply(8'h5A, 8'hC3, 1'b1, 4'b1111, 4'b1111, 4'b1010);
    check("R2 kill beats propagate", 32'(carry_out), 32'd0);
    check("R2 kill beats propagate bits", 32'(result), 32'h01);
    apply(8'h5A, 8'hC3, 1'b0, 4'b0000, 4'b0000, 4'b0000);
    check("R2 generate", 32'(carry_out), 32'd1);
    for (int ci = 0; ci < 2; ci++) begin
      apply(8'h3C, 8'hA5, 1'(ci), 4'b1111, 4'b0000, 4'b1010);
      check("R4 carry pass result", 32'(result), ci ? 32'(MASK) : 32'd0);
      check("R4 carry pass out", 32'(carry_out), 32'(ci));
    end
  endtask

  task automatic t_result_table;
    // R3: result = NOT propagate (NAND with AND propagate table)
    apply(8'hF0, 8'hAA, 1'b0, 4'b1000, 4'b1111, 4'b0011);
    check("R3 nand", 32'(result), 32'(~(8'hF0 & 8'hAA) & MASK));
    // R3: result = p AND c; kill in bit 4 (a=0,b=1) clears carry above it
    apply(8'h0F, 8'h10, 1'b1, 4'b1111, 4'b0010, 4'b1000);
    check("R3 p&c", 32'(result), 32'h1F);
    check_flags("R8 R9 table");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_carry_rules();
    t_result_table();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule